// File: doc/BRIEF.md
# Add-Only EPROM Page Manager

This block is the memory command layer that sits behind a single-wire slave front end. Its host is the bit-level engine. The host passes received bytes in over a one-cycle `rx_valid` strobe. It asks for outgoing bytes with a one-cycle `tx_req` strobe. Behind the command layer sit two internal arrays, both erased to all ones at reset:

- a 2048-byte main memory, organised as 64 pages of 32 bytes;
- a status memory, holding one write-protect bit per page and one redirection byte per page.

Stored bits can only move from 1 to 0. A program operation therefore merges the new byte into the stored byte with a bitwise AND.

A transaction starts with a command byte, followed by a 16-bit address sent low byte first. Five commands are supported: 0xF0 reads main memory, 0xAA reads status memory, 0xA5 reads a page's redirection byte, 0x0F programs main memory and 0x55 programs status memory. Every transfer carries a CRC-16. The block never compares that CRC against anything. The master alone decides whether to commit a program by issuing `prog_pulse`. A page is retired by programming the one's complement of its replacement page number into its redirection byte, so 0xFD in page 1's byte points at page 2. The value 0xFF means the page is not redirected. `bus_reset` aborts any transaction.

Status address layout:

| Status address | Content | Bit order |
|---|---|---|
| 0x000 to 0x007 | Protect bits, 8 pages per byte | Bit i of byte k belongs to page 8k+i; a 0 bit means protected |
| 0x100 + p | Redirection byte of page p | Whole byte |
| Any other address | Reads as 0xFF | Programs have no effect |

Top module: `addonly_page_mgr`

## Requirements
- R1: After reset `tx_valid` is low, and every main and status byte reads as 0xFF.
- R2: Command 0xF0 returns main bytes one per `tx_req`, starting at the supplied address and incrementing. After address 0x7FF it sends the two CRC bytes, and every further request returns 0xFF.
- R3: The CRC is x^16+x^15+x^2+1, reflected (0xA001), starts at 0 and takes data LSB first. It is sent inverted, low byte first. For a read it covers the command, both address bytes and every data byte sent.
- R4: Command 0xAA returns status bytes from the supplied address up to and including the last byte of its 8-byte status page (address bits [2:0] = 7). The CRC follows.
- R5: Command 0xA5 returns the redirection byte of page `addr[10:5]`, then the CRC of the command, both address bytes and that byte.
- R6: After each program data byte the block returns a CRC. For the first byte it covers the command, both address bytes and the data. For each later byte it covers the current address (low, high) and the data.
- R7: A program is committed only when `prog_pulse` arrives after the CRC, whatever the master's CRC check found. The stored byte becomes the old byte AND the new byte. The next `tx_req` returns the stored byte, and the address then advances.
- R8: A main program to a page whose protect bit is 0 leaves the page unchanged. Status programs are always applied.
- R9: `prog_pulse` outside the wait-for-pulse step changes no stored byte.
- R10: `bus_reset` returns the block to waiting for a command. A request with no data to send, or an unknown command, returns 0xFF.
- R11: Every `tx_req` is answered by `tx_valid` high for exactly one cycle on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_reset | input | 1 | Aborts the current transaction |
| rx_valid | input | 1 | Strobe for a received byte |
| rx_byte | input | 8 | Received byte |
| tx_req | input | 1 | Request for the next outgoing byte |
| tx_valid | output | 1 | Outgoing byte valid, one cycle |
| tx_byte | output | 8 | Outgoing byte |
| prog_pulse | input | 1 | Master's program strobe |

## Verification
A received byte is taken at the edge where `rx_valid` is high. A requested byte appears on `tx_byte`, with `tx_valid`, one edge after `tx_req`. A program commits at the edge that samples `prog_pulse`, so the verify byte requested afterwards already shows the merged value. The bench drives every strobe at a falling edge for one cycle and samples outputs at the following falling edge, half a cycle after the registering edge. Expected CRCs are computed in the bench from R3 over the same byte sequence.

// File: rtl/apm_pkg.sv
package apm_pkg;

  typedef enum logic [3:0] {
    ST_CMD, ST_ALO, ST_AHI, ST_RD_MAIN, ST_RD_STAT, ST_RD_REDIR,
    ST_CRC_LO, ST_CRC_HI, ST_P_DATA, ST_P_CRC_LO, ST_P_CRC_HI,
    ST_P_PULSE, ST_P_VERIFY, ST_IDLE
  } apm_state_e;

  localparam logic [7:0] CMD_RD_MAIN  = 8'hF0;
  localparam logic [7:0] CMD_RD_STAT  = 8'hAA;
  localparam logic [7:0] CMD_RD_REDIR = 8'hA5;
  localparam logic [7:0] CMD_PG_MAIN  = 8'h0F;
  localparam logic [7:0] CMD_PG_STAT  = 8'h55;

  // Reflected CRC-16, polynomial 0xA001, one byte LSB first.
  function automatic logic [15:0] crc16_upd(input logic [15:0] c, input logic [7:0] d);
    logic [15:0] r;
    r = c;
    for (int i = 0; i < 8; i++) begin
      if (r[0] ^ d[i]) r = (r >> 1) ^ 16'hA001;
      else             r = r >> 1;
    end
    return r;
  endfunction

endpackage

// File: rtl/apm_crc16.sv
module apm_crc16 (
  input  logic        clk,
  input  logic        rst_ni,
  input  logic        ld_en,
  input  logic [15:0] ld_val,
  input  logic        sh_en,
  input  logic [7:0]  sh_byte,
  output logic [15:0] crc_o
);
  import apm_pkg::*;

  logic [15:0] crc_q, crc_d;

  always_comb begin
    crc_d = crc_q;
    if (ld_en)      crc_d = ld_val;
    else if (sh_en) crc_d = crc16_upd(crc_q, sh_byte);
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) crc_q <= 16'h0000;
    else         crc_q <= crc_d;
  end

  assign crc_o = crc_q;
endmodule

// File: rtl/apm_store.sv
module apm_store #(
  parameter int          PAGES      = 64,
  parameter int          PAGE_BYTES = 32,
  parameter logic [15:0] REDIR_BASE = 16'h0100
) (
  input  logic        clk,
  input  logic        rst_ni,
  input  logic [15:0] addr,
  input  logic        wr_en,
  input  logic        wr_stat,
  input  logic [7:0]  wr_data,
  output logic [7:0]  main_rd,
  output logic [7:0]  stat_rd,
  output logic [7:0]  redir_rd,
  output logic        page_prot
);
  localparam int MAIN_BYTES = PAGES * PAGE_BYTES;
  localparam int MAIN_AW    = $clog2(MAIN_BYTES);
  localparam int OFF_W      = $clog2(PAGE_BYTES);
  localparam int PAGE_W     = $clog2(PAGES);
  localparam int PROT_BYTES = PAGES / 8;
  localparam int PROT_AW    = $clog2(PROT_BYTES);
  localparam logic [15:0] PROT_END  = 16'(PROT_BYTES);
  localparam logic [15:0] REDIR_END = REDIR_BASE + 16'(PAGES);

  logic [7:0] main_mem  [MAIN_BYTES];
  logic [7:0] prot_mem  [PROT_BYTES];
  logic [7:0] redir_mem [PAGES];

  logic [PAGE_W-1:0] page;
  logic              prot_sel, redir_sel;
  logic [7:0]        prot_byte;

  assign page      = addr[MAIN_AW-1:OFF_W];
  assign prot_sel  = addr < PROT_END;
  assign redir_sel = (addr >= REDIR_BASE) && (addr < REDIR_END);
  assign prot_byte = prot_mem[page[PAGE_W-1:3]];
  assign page_prot = ~prot_byte[page[2:0]];

  assign main_rd  = main_mem[addr[MAIN_AW-1:0]];
  assign redir_rd = redir_mem[page];
  assign stat_rd  = prot_sel  ? prot_mem[addr[PROT_AW-1:0]] :
                    redir_sel ? redir_mem[addr[PAGE_W-1:0]] : 8'hFF;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < MAIN_BYTES; i++) main_mem[i] <= 8'hFF;
      for (int i = 0; i < PROT_BYTES; i++) prot_mem[i] <= 8'hFF;
      for (int i = 0; i < PAGES; i++)      redir_mem[i] <= 8'hFF;
    end else if (wr_en) begin
      if (wr_stat) begin
        if (prot_sel)
          prot_mem[addr[PROT_AW-1:0]] <= prot_mem[addr[PROT_AW-1:0]] & wr_data;
        else if (redir_sel)
          redir_mem[addr[PAGE_W-1:0]] <= redir_mem[addr[PAGE_W-1:0]] & wr_data;
      end else if (!page_prot) begin
        main_mem[addr[MAIN_AW-1:0]] <= main_mem[addr[MAIN_AW-1:0]] & wr_data;
      end
    end
  end
endmodule

// File: rtl/apm_ctrl.sv
module apm_ctrl #(
  parameter int          PAGES      = 64,
  parameter int          PAGE_BYTES = 32,
  parameter logic [15:0] REDIR_BASE = 16'h0100
) (
  input  logic                clk,
  input  logic                rst_ni,
  input  logic                bus_reset,
  input  logic                rx_valid,
  input  logic [7:0]          rx_byte,
  input  logic                tx_req,
  input  logic                prog_pulse,
  output logic                tx_valid,
  output logic [7:0]          tx_byte,
  output logic [15:0]         addr_o,
  input  logic [7:0]          main_rd,
  input  logic [7:0]          stat_rd,
  input  logic [7:0]          redir_rd,
  output logic                wr_en,
  output logic                wr_stat,
  output logic [7:0]          wr_data,
  output logic                crc_ld,
  output logic [15:0]         crc_ld_val,
  output logic                crc_sh,
  output logic [7:0]          crc_sh_byte,
  input  logic [15:0]         crc_i,
  output apm_pkg::apm_state_e state_o
);
  import apm_pkg::*;

  localparam logic [15:0] MAIN_LAST = 16'(PAGES * PAGE_BYTES - 1);
  localparam logic [15:0] STAT_LAST = REDIR_BASE + 16'(PAGES - 1);

  apm_state_e  state_q, state_d;
  logic [15:0] addr_q, addr_d, addr_nx, full_addr;
  logic [7:0]  cmd_q, cmd_d, data_q, data_d;
  logic        txv_q, txv_d;
  logic [7:0]  txb_q, txb_d;
  logic        pg_stat;

  assign pg_stat   = (cmd_q == CMD_PG_STAT);
  assign addr_nx   = addr_q + 16'd1;
  assign full_addr = {rx_byte, addr_q[7:0]};

  always_comb begin
    state_d     = state_q;
    addr_d      = addr_q;
    cmd_d       = cmd_q;
    data_d      = data_q;
    txv_d       = tx_req;
    txb_d       = 8'hFF;
    crc_ld      = 1'b0;
    crc_ld_val  = 16'h0000;
    crc_sh      = 1'b0;
    crc_sh_byte = 8'h00;
    wr_en       = 1'b0;
    if (bus_reset) begin
      state_d = ST_CMD;
    end else begin
      case (state_q)
        ST_CMD: if (rx_valid) begin
          cmd_d      = rx_byte;
          crc_ld     = 1'b1;
          crc_ld_val = crc16_upd(16'h0000, rx_byte);
          state_d    = ST_ALO;
        end
        ST_ALO: if (rx_valid) begin
          addr_d[7:0] = rx_byte;
          crc_sh      = 1'b1;
          crc_sh_byte = rx_byte;
          state_d     = ST_AHI;
        end
        ST_AHI: if (rx_valid) begin
          addr_d[15:8] = rx_byte;
          crc_sh       = 1'b1;
          crc_sh_byte  = rx_byte;
          case (cmd_q)
            CMD_RD_MAIN:  state_d = (full_addr <= MAIN_LAST) ? ST_RD_MAIN : ST_CRC_LO;
            CMD_RD_STAT:  state_d = ST_RD_STAT;
            CMD_RD_REDIR: state_d = ST_RD_REDIR;
            CMD_PG_MAIN:  state_d = (full_addr <= MAIN_LAST) ? ST_P_DATA : ST_IDLE;
            CMD_PG_STAT:  state_d = (full_addr <= STAT_LAST) ? ST_P_DATA : ST_IDLE;
            default:      state_d = ST_IDLE;
          endcase
        end
        ST_RD_MAIN: if (tx_req) begin
          txb_d       = main_rd;
          crc_sh      = 1'b1;
          crc_sh_byte = main_rd;
          if (addr_q == MAIN_LAST) state_d = ST_CRC_LO;
          else                     addr_d  = addr_nx;
        end
        ST_RD_STAT: if (tx_req) begin
          txb_d       = stat_rd;
          crc_sh      = 1'b1;
          crc_sh_byte = stat_rd;
          if (addr_q[2:0] == 3'b111) state_d = ST_CRC_LO;
          else                       addr_d  = addr_nx;
        end
        ST_RD_REDIR: if (tx_req) begin
          txb_d       = redir_rd;
          crc_sh      = 1'b1;
          crc_sh_byte = redir_rd;
          state_d     = ST_CRC_LO;
        end
        ST_CRC_LO: if (tx_req) begin
          txb_d   = ~crc_i[7:0];
          state_d = ST_CRC_HI;
        end
        ST_CRC_HI: if (tx_req) begin
          txb_d   = ~crc_i[15:8];
          state_d = ST_IDLE;
        end
        ST_P_DATA: if (rx_valid) begin
          data_d      = rx_byte;
          crc_sh      = 1'b1;
          crc_sh_byte = rx_byte;
          state_d     = ST_P_CRC_LO;
        end
        ST_P_CRC_LO: if (tx_req) begin
          txb_d   = ~crc_i[7:0];
          state_d = ST_P_CRC_HI;
        end
        ST_P_CRC_HI: if (tx_req) begin
          txb_d   = ~crc_i[15:8];
          state_d = ST_P_PULSE;
        end
        ST_P_PULSE: if (prog_pulse) begin
          wr_en   = 1'b1;
          state_d = ST_P_VERIFY;
        end
        ST_P_VERIFY: if (tx_req) begin
          txb_d = pg_stat ? stat_rd : main_rd;
          if (addr_q == (pg_stat ? STAT_LAST : MAIN_LAST)) begin
            state_d = ST_IDLE;
          end else begin
            addr_d     = addr_nx;
            crc_ld     = 1'b1;
            crc_ld_val = crc16_upd(crc16_upd(16'h0000, addr_nx[7:0]), addr_nx[15:8]);
            state_d    = ST_P_DATA;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_CMD;
      addr_q  <= 16'h0000;
      cmd_q   <= 8'h00;
      data_q  <= 8'hFF;
      txv_q   <= 1'b0;
      txb_q   <= 8'hFF;
    end else begin
      state_q <= state_d;
      addr_q  <= addr_d;
      cmd_q   <= cmd_d;
      data_q  <= data_d;
      txv_q   <= txv_d;
      txb_q   <= txb_d;
    end
  end

  assign tx_valid = txv_q;
  assign tx_byte  = txb_q;
  assign addr_o   = addr_q;
  assign wr_stat  = pg_stat;
  assign wr_data  = data_q;
  assign state_o  = state_q;
endmodule

// File: rtl/addonly_page_mgr.sv
module addonly_page_mgr #(
  parameter int          PAGES      = 64,
  parameter int          PAGE_BYTES = 32,
  parameter logic [15:0] REDIR_BASE = 16'h0100
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_reset,
  input  logic       rx_valid,
  input  logic [7:0] rx_byte,
  input  logic       tx_req,
  output logic       tx_valid,
  output logic [7:0] tx_byte,
  input  logic       prog_pulse
);
  import apm_pkg::*;

  logic [1:0]  rst_sync;
  logic        rst_ni;
  logic [15:0] addr;
  logic [7:0]  main_rd, stat_rd, redir_rd, wr_data, crc_sh_byte;
  logic        wr_en, wr_stat, page_prot, crc_ld, crc_sh;
  logic [15:0] crc_ld_val, crc;
  apm_state_e  state;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_ni = rst_sync[1];

  apm_ctrl #(.PAGES(PAGES), .PAGE_BYTES(PAGE_BYTES), .REDIR_BASE(REDIR_BASE)) ctrl_i (
    .clk(clk), .rst_ni(rst_ni), .bus_reset(bus_reset), .rx_valid(rx_valid),
    .rx_byte(rx_byte), .tx_req(tx_req), .prog_pulse(prog_pulse),
    .tx_valid(tx_valid), .tx_byte(tx_byte), .addr_o(addr),
    .main_rd(main_rd), .stat_rd(stat_rd), .redir_rd(redir_rd),
    .wr_en(wr_en), .wr_stat(wr_stat), .wr_data(wr_data),
    .crc_ld(crc_ld), .crc_ld_val(crc_ld_val), .crc_sh(crc_sh),
    .crc_sh_byte(crc_sh_byte), .crc_i(crc), .state_o(state)
  );

  apm_crc16 crc_i (
    .clk(clk), .rst_ni(rst_ni), .ld_en(crc_ld), .ld_val(crc_ld_val),
    .sh_en(crc_sh), .sh_byte(crc_sh_byte), .crc_o(crc)
  );

  apm_store #(.PAGES(PAGES), .PAGE_BYTES(PAGE_BYTES), .REDIR_BASE(REDIR_BASE)) store_i (
    .clk(clk), .rst_ni(rst_ni), .addr(addr), .wr_en(wr_en), .wr_stat(wr_stat),
    .wr_data(wr_data), .main_rd(main_rd), .stat_rd(stat_rd),
    .redir_rd(redir_rd), .page_prot(page_prot)
  );
endmodule

// File: rtl/apm_checker.sv
module apm_checker (
  input logic                clk,
  input logic                rst_ni,
  input logic                tx_req,
  input logic                tx_valid,
  input logic                bus_reset,
  input logic                prog_pulse,
  input logic                wr_en,
  input logic                wr_stat,
  input logic                page_prot,
  input logic [7:0]          main_rd,
  input apm_pkg::apm_state_e state
);
  import apm_pkg::*;

  a_r11_tx_follows_req: assert property (@(posedge clk) disable iff (!rst_ni)
    tx_req |=> tx_valid);
  a_r11_tx_single: assert property (@(posedge clk) disable iff (!rst_ni)
    !tx_req |=> !tx_valid);
  a_r7_write_needs_pulse: assert property (@(posedge clk) disable iff (!rst_ni)
    wr_en |-> prog_pulse);
  a_r7_bits_only_clear: assert property (@(posedge clk) disable iff (!rst_ni)
    (wr_en && !wr_stat) |=> ((main_rd & ~$past(main_rd)) == 8'h00));
  a_r8_protected_holds: assert property (@(posedge clk) disable iff (!rst_ni)
    (wr_en && !wr_stat && page_prot) |=> $stable(main_rd));
  a_r10_abort_to_cmd: assert property (@(posedge clk) disable iff (!rst_ni)
    bus_reset |=> (state == ST_CMD));
endmodule

bind addonly_page_mgr apm_checker chk_i (
  .clk(clk), .rst_ni(rst_ni), .tx_req(tx_req), .tx_valid(tx_valid),
  .bus_reset(bus_reset), .prog_pulse(prog_pulse), .wr_en(wr_en),
  .wr_stat(wr_stat), .page_prot(page_prot), .main_rd(main_rd), .state(state)
);

// File: tb/addonly_page_mgr_tb_top.sv
module addonly_page_mgr_tb_top;
  logic       clk = 1'b0;
  logic       rst_n, bus_reset, rx_valid, tx_req, prog_pulse, tx_valid;
  logic [7:0] rx_byte, tx_byte;
  int         n_chk = 0, n_bad = 0;

  always #5 clk = ~clk;

  addonly_page_mgr dut_i (
    .clk(clk), .rst_n(rst_n), .bus_reset(bus_reset), .rx_valid(rx_valid),
    .rx_byte(rx_byte), .tx_req(tx_req), .tx_valid(tx_valid),
    .tx_byte(tx_byte), .prog_pulse(prog_pulse)
  );

  function automatic logic [15:0] ref_crc(input logic [15:0] c, input logic [7:0] b);
    logic [15:0] r;
    r = c ^ {8'h00, b};
    for (int k = 0; k < 8; k++) r = r[0] ? ((r >> 1) ^ 16'hA001) : (r >> 1);
    return r;
  endfunction

  task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic put(input logic [7:0] b);
    @(negedge clk); rx_valid = 1'b1; rx_byte = b;
    @(negedge clk); rx_valid = 1'b0;
  endtask

  task automatic get(input string req, output logic [7:0] b);
    @(negedge clk); tx_req = 1'b1;
    @(negedge clk); tx_req = 1'b0;
    check({req, " tx_valid (R11)"}, {15'd0, tx_valid}, 16'd1);
    b = tx_byte;
  endtask

  task automatic pulse();
    @(negedge clk); prog_pulse = 1'b1;
    @(negedge clk); prog_pulse = 1'b0;
  endtask

  task automatic abort();
    @(negedge clk); bus_reset = 1'b1;
    @(negedge clk); bus_reset = 1'b0;
  endtask

  task automatic expect_crc(input string req, input logic [15:0] c);
    logic [7:0] lo, hi;
    get(req, lo);
    get(req, hi);
    check({req, " crc"}, {hi, lo}, ~c);
  endtask

  task automatic start(input logic [7:0] cmd, input logic [15:0] a, inout logic [15:0] c);
    put(cmd); put(a[7:0]); put(a[15:8]);
    c = ref_crc(ref_crc(ref_crc(16'h0, cmd), a[7:0]), a[15:8]);
  endtask

  // One program step; the CRC is checked against the running value c.
  task automatic prog_step(input string req, input logic [7:0] d, input logic [15:0] c,
                           input logic [7:0] exp_stored);
    logic [7:0] v;
    put(d);
    expect_crc({req, " R6"}, ref_crc(c, d));
    pulse();
    get(req, v);
    check({req, " verify R7"}, {8'h0, v}, {8'h0, exp_stored});
  endtask

  task automatic t_reset();
    logic [15:0] c;
    logic [7:0]  v;
    check("R1 tx_valid after reset", {15'd0, tx_valid}, 16'd0);
    start(8'hF0, 16'h0000, c);
    get("R1", v);
    check("R1 erased main", {8'h0, v}, 16'h00FF);
    abort();
    start(8'hAA, 16'h0100, c);
    get("R1", v);
    check("R1 erased status", {8'h0, v}, 16'h00FF);
    abort();
  endtask

  task automatic t_read_end();
    logic [15:0] c;
    logic [7:0]  v;
    start(8'hF0, 16'h07FC, c);
    for (int i = 0; i < 4; i++) begin
      get("R2", v);
      check("R2 data near end", {8'h0, v}, 16'h00FF);
      c = ref_crc(c, v);
    end
    expect_crc("R2 R3 main read", c);
    get("R10", v);
    check("R10 after crc", {8'h0, v}, 16'h00FF);
    abort();
  endtask

  task automatic t_program();
    logic [15:0] c;
    logic [7:0]  v;
    start(8'h0F, 16'h0040, c);
    prog_step("R7 first", 8'hA5, c, 8'hA5);
    c = ref_crc(ref_crc(16'h0, 8'h41), 8'h00);
    prog_step("R6 second", 8'h3C, c, 8'h3C);
    abort();
    start(8'h0F, 16'h0040, c);
    prog_step("R7 and-merge", 8'hF0, c, 8'hA0);
    abort();
    start(8'hF0, 16'h0040, c);
    get("R2", v); check("R2 readback 0x40", {8'h0, v}, 16'h00A0); c = ref_crc(c, v);
    get("R2", v); check("R2 readback 0x41", {8'h0, v}, 16'h003C);
    abort();
  endtask

  task automatic t_no_pulse();
    logic [15:0] c;
    logic [7:0]  v;
    start(8'h0F, 16'h0050, c);
    put(8'h00);
    expect_crc("R6 no-pulse", ref_crc(c, 8'h00));
    abort();
    start(8'hF0, 16'h0060, c);
    pulse();
    get("R9", v);
    abort();
    start(8'hF0, 16'h0050, c);
    get("R7", v);
    check("R7 no pulse no commit", {8'h0, v}, 16'h00FF);
    abort();
    start(8'hF0, 16'h0060, c);
    get("R9", v);
    check("R9 pulse in read ignored", {8'h0, v}, 16'h00FF);
    abort();
  endtask

  task automatic t_protect();
    logic [15:0] c;
    logic [7:0]  v;
    start(8'h55, 16'h0000, c);
    prog_step("R8 set protect", 8'hFE, c, 8'hFE);
    abort();
    start(8'h0F, 16'h0005, c);
    prog_step("R8 protected page", 8'h00, c, 8'hFF);
    abort();
    start(8'hF0, 16'h0005, c);
    get("R8", v);
    check("R8 protected readback", {8'h0, v}, 16'h00FF);
    abort();
    start(8'h0F, 16'h0025, c);
    prog_step("R8 unprotected page", 8'h11, c, 8'h11);
    abort();
  endtask

  task automatic t_status_read();
    logic [15:0] c;
    logic [7:0]  v;
    start(8'hAA, 16'h0000, c);
    for (int i = 0; i < 8; i++) begin
      get("R4", v);
      check("R4 status byte", {8'h0, v}, (i == 0) ? 16'h00FE : 16'h00FF);
      c = ref_crc(c, v);
    end
    expect_crc("R4 R3 status crc", c);
    abort();
  endtask

  task automatic t_redirect();
    logic [15:0] c;
    logic [7:0]  v;
    start(8'h55, 16'h0101, c);
    prog_step("R5 set redirect", 8'hFD, c, 8'hFD);
    abort();
    start(8'hA5, 16'h0020, c);
    get("R5", v);
    check("R5 redirect page1", {8'h0, v}, 16'h00FD);
    expect_crc("R5 redirect", ref_crc(c, v));
    get("R10", v);
    check("R10 idle after redirect", {8'h0, v}, 16'h00FF);
    abort();
    start(8'hA5, 16'h0047, c);
    get("R5", v);
    check("R5 redirect page2 unset", {8'h0, v}, 16'h00FF);
    abort();
  endtask

  task automatic t_unknown();
    logic [15:0] c;
    logic [7:0]  v;
    start(8'h33, 16'h0000, c);
    get("R10", v);
    check("R10 unknown command", {8'h0, v}, 16'h00FF);
    abort();
    @(negedge clk);
    check("R11 no request no valid", {15'd0, tx_valid}, 16'd0);
  endtask

  initial begin
    rst_n = 1'b0; bus_reset = 1'b0; rx_valid = 1'b0; rx_byte = 8'h00;
    tx_req = 1'b0; prog_pulse = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_read_end();
    t_program();
    t_no_pulse();
    t_protect();
    t_status_read();
    t_redirect();
    t_unknown();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule